// File: doc/BRIEF.md
# Constant Off-Time Gate Sequencer

This block drives the power switch of a hysteretic peak-current LED converter that runs with a constant off-time. An on-time starts with the gate high. After a short window in which the current comparators are ignored, the on-time ends as soon as the sensed current reaches the controlled reference. The gate then stays low while an external capacitor charges. When that capacitor reaches its threshold, the block discharges it for a short fixed pulse and starts the next on-time. A hard off-time ceiling and a programmable on-time ceiling keep the switch cycling when a comparator never fires.

Around this cycle sit the protections. A hard current limit stops switching for a fixed hold-off. A supply overvoltage locks the gate off until a long timeout has run and the supply has fallen by a margin. An overtemperature flag holds the gate low for as long as it is set. A supply window with hysteresis decides when the block is enabled at all. All inputs are comparator flags from the analog side, and every one of them is resynchronised before use. All durations are counted in clock cycles and set by parameters.

Top module: `cot_gate_ctrl`

## Requirements
- R1: Every comparator input passes through two synchronizer flops, so a flag first seen at clock edge k can change the outputs at edge k+2 at the earliest. A reference trip first driven during on-time cycle n therefore gives an on-time of n+3 cycles.
- R2: For the first BLANK_CYC cycles of an on-time, the reference and hard-limit flags are ignored. If the reference flag is high from the start, the on-time lasts exactly BLANK_CYC+1 cycles.
- R3: After blanking, a high reference flag ends the on-time. The gate goes low and the discharge output goes low while the off-time runs.
- R4: The capacitor-threshold flag ends the off-time. The discharge output is then high for DISCH_CYC cycles, after which the gate goes high. The gate only ever rises in the cycle after the discharge output was high.
- R5: An off-time that sees no capacitor threshold ends after exactly OFF_MAX_CYC cycles.
- R6: With no reference or limit trip, the on-time ends after maxOnLimit cycles and the off-time follows. A limit of 0 acts as 1.
- R7: A hard-limit flag seen after blanking ends the on-time. The reference flag has lower priority. The discharge output is then high and the gate low for ILIM_HOLD_CYC cycles, after which a new on-time starts.
- R8: An overvoltage flag forces the gate low and the discharge output high. Switching resumes only once at least OVP_HOLD_CYC cycles have passed in this lockout, the supply-dropped flag is high and the overvoltage flag is low.
- R9: An overtemperature flag holds the gate low and the discharge output high. The next cycle after the flag clears starts a new on-time. Overvoltage takes precedence over overtemperature.
- R10: After reset the block is shut down, with the gate low and the discharge output high. It stays shut down until the above-on flag is seen. Once enabled, it keeps switching until the below-off flag is seen, even if the above-on flag drops. Shutdown has the highest priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| senseRef | input | 1 | Sensed current at or above the controlled reference |
| senseLimit | input | 1 | Sensed current above the hard limit |
| capAtThresh | input | 1 | Off-time capacitor has reached its threshold |
| vccAboveOn | input | 1 | Supply above the enable (rising) threshold |
| vccBelowOff | input | 1 | Supply below the disable (falling) threshold |
| vccOver | input | 1 | Supply above the overvoltage trip |
| vccDropped | input | 1 | Supply at least the release margin below the overvoltage trip |
| overTemp | input | 1 | Die overtemperature flag (hysteresis applied outside) |
| maxOnLimit | input | ON_W | On-time ceiling in cycles |
| gateOut | output | 1 | Power switch gate command |
| dischOut | output | 1 | Off-time capacitor discharge command |

## Verification
The hardest situations to reach from the ports are the protection releases that depend on timing. One is an overvoltage lockout whose timeout expires while the supply-dropped flag is still low, so the release must wait for the flag and not for the counter. The other is a hard-limit trip that lands exactly on the first cycle after blanking. The bench gets there with a reactive plant model. The plant raises the reference and capacitor flags a chosen number of cycles after it sees the gate change. Fault flags are raised in the middle of whatever phase is running, and the release flags are held back past the timeout. A behavioural model then tracks both outputs cycle by cycle through these sequences.

// File: rtl/cot_pkg.sv
package cot_pkg;

  typedef enum logic [2:0] {
    PH_SHUT  = 3'd0,
    PH_ON    = 3'd1,
    PH_OFF   = 3'd2,
    PH_DISCH = 3'd3,
    PH_ILIM  = 3'd4,
    PH_OVP   = 3'd5,
    PH_HOT   = 3'd6
  } phase_e;

  // synchronised comparator flags
  typedef struct packed {
    logic overTemp;
    logic vccDropped;
    logic vccOver;
    logic vccBelowOff;
    logic vccAboveOn;
    logic capAtThresh;
    logic senseLimit;
    logic senseRef;
  } flags_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clearCnt;
    logic countEn;
  } strobes_t;

  // datapath -> control timer status
  typedef struct packed {
    logic blankDone;
    logic onMaxHit;
    logic offTimeout;
    logic dischDone;
    logic ilimDone;
    logic ovpDone;
  } timers_t;

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cot_sync.sv
module cot_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end
endmodule

// File: rtl/cot_datapath.sv
module cot_datapath
  import cot_pkg::*;
#(
  parameter int unsigned BLANK_CYC     = 24,
  parameter int unsigned OFF_MAX_CYC   = 28000,
  parameter int unsigned DISCH_CYC     = 20,
  parameter int unsigned ILIM_HOLD_CYC = 28000,
  parameter int unsigned OVP_HOLD_CYC  = 100000000,
  parameter int unsigned ON_W          = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        strobes,
  input  logic [ON_W-1:0] maxOnLimit,
  output timers_t         timers
);
  localparam int unsigned LONGEST = maxOf(maxOf(maxOf(OFF_MAX_CYC, ILIM_HOLD_CYC),
                                                maxOf(OVP_HOLD_CYC, DISCH_CYC)),
                                          maxOf(BLANK_CYC + 1, 2 ** ON_W));
  localparam int CNT_W = $clog2(LONGEST + 1);
  localparam int CW1   = CNT_W + 1;

  logic [CNT_W-1:0] phaseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strobes.clearCnt) begin
      phaseCnt <= '0;
    end else if (strobes.countEn && (phaseCnt != {CNT_W{1'b1}})) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_comb begin
    timers.blankDone  = phaseCnt >= CNT_W'(BLANK_CYC);
    timers.onMaxHit   = (CW1'(phaseCnt) + CW1'(1)) >= CW1'(maxOnLimit);
    timers.offTimeout = phaseCnt >= CNT_W'(OFF_MAX_CYC - 1);
    timers.dischDone  = phaseCnt >= CNT_W'(DISCH_CYC - 1);
    timers.ilimDone   = phaseCnt >= CNT_W'(ILIM_HOLD_CYC - 1);
    timers.ovpDone    = phaseCnt >= CNT_W'(OVP_HOLD_CYC - 1);
  end
endmodule

// File: rtl/cot_control.sv
module cot_control
  import cot_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  flags_t   flags,
  input  timers_t  timers,
  output strobes_t strobes,
  output logic     gateOut,
  output logic     dischOut
);
  phase_e phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    if (phase == PH_SHUT) begin
      if (flags.vccAboveOn)
        phaseNext = flags.vccOver ? PH_OVP : (flags.overTemp ? PH_HOT : PH_ON);
    end else if (flags.vccBelowOff) begin
      phaseNext = PH_SHUT;
    end else if (phase == PH_OVP) begin
      if (timers.ovpDone && flags.vccDropped && !flags.vccOver)
        phaseNext = flags.overTemp ? PH_HOT : PH_ON;
    end else if (flags.vccOver) begin
      phaseNext = PH_OVP;
    end else if (flags.overTemp) begin
      phaseNext = PH_HOT;
    end else begin
      unique case (phase)
        PH_ON: begin
          if (timers.blankDone && flags.senseLimit)   phaseNext = PH_ILIM;
          else if (timers.blankDone && flags.senseRef) phaseNext = PH_OFF;
          else if (timers.onMaxHit)                    phaseNext = PH_OFF;
        end
        PH_OFF:   if (flags.capAtThresh || timers.offTimeout) phaseNext = PH_DISCH;
        PH_DISCH: if (timers.dischDone) phaseNext = PH_ON;
        PH_ILIM:  if (timers.ilimDone)  phaseNext = PH_ON;
        PH_HOT:   phaseNext = PH_ON;
        default:  phaseNext = PH_SHUT;
      endcase
    end
  end

  always_comb begin
    strobes.clearCnt = (phaseNext != phase);
    strobes.countEn  = (phase != PH_SHUT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_SHUT;
      gateOut  <= 1'b0;
      dischOut <= 1'b1;
    end else begin
      phase    <= phaseNext;
      gateOut  <= (phaseNext == PH_ON);
      dischOut <= (phaseNext != PH_ON) && (phaseNext != PH_OFF);
    end
  end
endmodule

// File: rtl/cot_gate_ctrl.sv
module cot_gate_ctrl
  import cot_pkg::*;
#(
  parameter int unsigned BLANK_CYC     = 24,
  parameter int unsigned OFF_MAX_CYC   = 28000,
  parameter int unsigned DISCH_CYC     = 20,
  parameter int unsigned ILIM_HOLD_CYC = 28000,
  parameter int unsigned OVP_HOLD_CYC  = 100000000,
  parameter int unsigned ON_W          = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            senseRef,
  input  logic            senseLimit,
  input  logic            capAtThresh,
  input  logic            vccAboveOn,
  input  logic            vccBelowOff,
  input  logic            vccOver,
  input  logic            vccDropped,
  input  logic            overTemp,
  input  logic [ON_W-1:0] maxOnLimit,
  output logic            gateOut,
  output logic            dischOut
);
  localparam int FLAG_W = $bits(flags_t);

  flags_t   rawFlags, syncFlags;
  strobes_t strobes;
  timers_t  timers;

  always_comb begin
    rawFlags.senseRef    = senseRef;
    rawFlags.senseLimit  = senseLimit;
    rawFlags.capAtThresh = capAtThresh;
    rawFlags.vccAboveOn  = vccAboveOn;
    rawFlags.vccBelowOff = vccBelowOff;
    rawFlags.vccOver     = vccOver;
    rawFlags.vccDropped  = vccDropped;
    rawFlags.overTemp    = overTemp;
  end

  cot_sync #(.WIDTH(FLAG_W)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(rawFlags),
    .syncOut(syncFlags)
  );

  cot_datapath #(
    .BLANK_CYC    (BLANK_CYC),
    .OFF_MAX_CYC  (OFF_MAX_CYC),
    .DISCH_CYC    (DISCH_CYC),
    .ILIM_HOLD_CYC(ILIM_HOLD_CYC),
    .OVP_HOLD_CYC (OVP_HOLD_CYC),
    .ON_W         (ON_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .maxOnLimit(maxOnLimit),
    .timers    (timers)
  );

  cot_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .flags   (syncFlags),
    .timers  (timers),
    .strobes (strobes),
    .gateOut (gateOut),
    .dischOut(dischOut)
  );
endmodule

// File: rtl/cot_gate_checker.sv
module cot_gate_checker #(
  parameter int unsigned BLANK_CYC   = 24,
  parameter int unsigned OFF_MAX_CYC = 28000,
  parameter int unsigned ON_W        = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            gateOut,
  input logic            dischOut,
  input logic            syncOver,
  input logic            syncHot,
  input logic            syncLow,
  input logic [ON_W-1:0] maxOnLimit
);
  int unsigned onRun, offRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onRun  <= 0;
      offRun <= 0;
    end else begin
      onRun  <= gateOut ? onRun + 1 : 0;
      offRun <= (!gateOut && !dischOut) ? offRun + 1 : 0;
    end
  end

  // R2: a normal on-time never ends inside the blanking window
  p_blank_min_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateOut) |-> (onRun > BLANK_CYC || onRun >= maxOnLimit ||
                        $past(syncOver || syncHot || syncLow)));

  // R4: the gate only rises right after a discharge or disabled cycle
  p_rise_after_disch_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOut) |-> $past(dischOut));

  // R5: the charging phase never outlasts the ceiling
  p_off_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    offRun <= OFF_MAX_CYC);

  // R8: overvoltage seen -> gate low next cycle
  p_ovp_gate_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    syncOver |=> !gateOut);

  // R9: overtemperature seen -> gate low next cycle
  p_hot_gate_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    syncHot |=> !gateOut);

  // R10: below-off seen -> gate low next cycle
  p_uv_gate_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    syncLow |=> !gateOut);
endmodule

bind cot_gate_ctrl cot_gate_checker #(
  .BLANK_CYC  (BLANK_CYC),
  .OFF_MAX_CYC(OFF_MAX_CYC),
  .ON_W       (ON_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .gateOut   (gateOut),
  .dischOut  (dischOut),
  .syncOver  (syncFlags.vccOver),
  .syncHot   (syncFlags.overTemp),
  .syncLow   (syncFlags.vccBelowOff),
  .maxOnLimit(maxOnLimit)
);

// File: tb/cot_gate_ctrl_tb.sv
module cot_gate_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK = 4;
  localparam int OFFMAX = 40;
  localparam int DISCH = 3;
  localparam int ILIM = 30;
  localparam int OVP = 60;
  localparam int ONW = 8;

  localparam int S_SHUT = 0, S_ON = 1, S_OFF = 2, S_DIS = 3, S_ILIM = 4, S_OVP = 5, S_HOT = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic senseRef = 0, senseLimit = 0, capAtThresh = 0, vccAboveOn = 0;
  logic vccBelowOff = 0, vccOver = 0, vccDropped = 0, overTemp = 0;
  logic [ONW-1:0] maxOnLimit = 8'd200;
  logic gateOut, dischOut;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cot_gate_ctrl #(
    .BLANK_CYC(BLANK), .OFF_MAX_CYC(OFFMAX), .DISCH_CYC(DISCH),
    .ILIM_HOLD_CYC(ILIM), .OVP_HOLD_CYC(OVP), .ON_W(ONW)
  ) u_dut (
    .clk(clk), .rstN(rstN), .senseRef(senseRef), .senseLimit(senseLimit),
    .capAtThresh(capAtThresh), .vccAboveOn(vccAboveOn), .vccBelowOff(vccBelowOff),
    .vccOver(vccOver), .vccDropped(vccDropped), .overTemp(overTemp),
    .maxOnLimit(maxOnLimit), .gateOut(gateOut), .dischOut(dischOut)
  );

  int checks = 0, errors = 0;
  string curReq = "R10";
  bit done = 0;

  // ---------------- behavioural reference model ----------------
  logic [7:0] pipe[$];
  int mState = S_SHUT, mCnt = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe = {};
      pipe.push_back(8'h00);
      pipe.push_back(8'h00);
      mState = S_SHUT;
      mCnt = 0;
    end else begin
      logic [7:0] u;
      int nxt;
      u = pipe.pop_front();
      pipe.push_back({overTemp, vccDropped, vccOver, vccBelowOff,
                      vccAboveOn, capAtThresh, senseLimit, senseRef});
      nxt = mState;
      if (mState == S_SHUT) begin
        if (u[3]) nxt = u[5] ? S_OVP : (u[7] ? S_HOT : S_ON);
      end else if (u[4]) nxt = S_SHUT;
      else if (mState == S_OVP) begin
        if (mCnt >= OVP - 1 && u[6] && !u[5]) nxt = u[7] ? S_HOT : S_ON;
      end else if (u[5]) nxt = S_OVP;
      else if (u[7]) nxt = S_HOT;
      else begin
        case (mState)
          S_ON: begin
            if (mCnt >= BLANK && u[1]) nxt = S_ILIM;
            else if (mCnt >= BLANK && u[0]) nxt = S_OFF;
            else if (mCnt + 1 >= int'(maxOnLimit)) nxt = S_OFF;
          end
          S_OFF:  if (u[2] || mCnt >= OFFMAX - 1) nxt = S_DIS;
          S_DIS:  if (mCnt >= DISCH - 1) nxt = S_ON;
          S_ILIM: if (mCnt >= ILIM - 1) nxt = S_ON;
          S_HOT:  nxt = S_ON;
          default: ;
        endcase
      end
      mCnt = (nxt != mState) ? 0 : mCnt + 1;
      mState = nxt;
    end
  end

  // ---------------- plant, comparison, pulse measurement ----------------
  int refDelay = 1000, capDelay = 1000;
  int gateAge = 0, chargeAge = 0;
  int onLen = 0, offLen = 0, disLen = 0;
  int lastOn = 0, lastOff = 0, lastDis = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        logic expG, expD;
        expG = (mState == S_ON);
        expD = (mState != S_ON) && (mState != S_OFF);
        checks++;
        if (gateOut !== expG || dischOut !== expD) begin
          errors++;
          $display("FAIL %s cycle compare: actual gate=%b disch=%b expected gate=%b disch=%b",
                   curReq, gateOut, dischOut, expG, expD);
        end
      end
      gateAge   = gateOut ? gateAge + 1 : 0;
      chargeAge = (!gateOut && !dischOut) ? chargeAge + 1 : 0;
      senseRef    = gateOut && (gateAge > refDelay);
      capAtThresh = (!gateOut && !dischOut) && (chargeAge > capDelay);
      if (gateOut) onLen++;
      else if (onLen != 0) begin lastOn = onLen; onLen = 0; end
      if (!gateOut && !dischOut) offLen++;
      else if (offLen != 0) begin lastOff = offLen; offLen = 0; end
      if (dischOut) disLen++;
      else if (disLen != 0) begin lastDis = disLen; disLen = 0; end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    run(3);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R10";
    check("R10", gateOut, 0, "gate after reset");
    check("R10", dischOut, 1, "discharge after reset");
    refDelay = 0;
    run(30);
    check("R10", gateOut, 0, "gate while not yet enabled");

    // R3/R4/R1: normal cycling, reference after 8 cycles, threshold after 10
    curReq = "R3"; refDelay = 8; capDelay = 10; vccAboveOn = 1;
    run(150);
    check("R1", lastOn, 8 + 3, "on-time with reference trip at cycle 8");
    check("R3", lastOff, 10 + 3, "off-time with threshold trip at cycle 10");
    check("R4", lastDis, DISCH, "discharge pulse length");

    // R2: reference high from the start
    curReq = "R2"; refDelay = 0;
    run(100);
    check("R2", lastOn, BLANK + 1, "on-time with reference held");

    // R6: no reference, on-time ceiling
    curReq = "R6"; refDelay = 1000; maxOnLimit = 8'd20;
    run(120);
    check("R6", lastOn, 20, "on-time at ceiling");
    maxOnLimit = 8'd0;
    run(60);
    check("R6", lastOn, 1, "on-time with zero ceiling");
    maxOnLimit = 8'd200; refDelay = 6;

    // R5: threshold never reached
    curReq = "R5"; capDelay = 1000;
    run(200);
    check("R5", lastOff, OFFMAX, "off-time ceiling");
    capDelay = 10;

    // R7: hard limit held, reference also trips (lower priority)
    curReq = "R7"; senseLimit = 1; refDelay = 0;
    run(150);
    check("R7", lastOn, BLANK + 1, "on-time on hard limit");
    check("R7", lastDis, ILIM, "hold-off after hard limit");
    senseLimit = 0; refDelay = 8;
    run(80);

    // R8: overvoltage, drop flag late
    curReq = "R8"; vccOver = 1;
    run(3);
    vccOver = 0;
    run(100);
    check("R8", gateOut, 0, "gate held past timeout without drop flag");
    check("R8", dischOut, 1, "discharge during lockout");
    vccDropped = 1;
    run(60);
    vccOver = 1;
    run(2);
    vccOver = 0;
    run(40);
    check("R8", gateOut, 0, "gate before timeout with drop flag set");
    run(100);
    vccDropped = 0;

    // R9: overtemperature, then together with overvoltage
    curReq = "R9"; overTemp = 1;
    run(40);
    check("R9", gateOut, 0, "gate during overtemperature");
    check("R9", dischOut, 1, "discharge during overtemperature");
    overTemp = 0;
    run(40);
    overTemp = 1; vccOver = 1;
    run(5);
    vccOver = 0;
    run(20);
    overTemp = 0; vccDropped = 1;
    run(120);
    vccDropped = 0;

    // R10: hysteresis and shutdown
    curReq = "R10"; vccAboveOn = 0;
    run(60);
    check("R10", (lastOn > 0) ? 1 : 0, 1, "still switching after above-on drops");
    vccBelowOff = 1;
    run(20);
    check("R10", gateOut, 0, "gate in shutdown");
    vccBelowOff = 0;
    run(30);
    check("R10", gateOut, 0, "gate stays off until above-on");
    check("R10", dischOut, 1, "discharge in shutdown");
    vccAboveOn = 1;
    run(60);

    done = 1;
    summary();
    $finish;
  end
endmodule